// File: doc/BRIEF.md
# Multi-Channel Interval Timer Register Front End

This block places two or three down-counting interval timers behind a single 4 KiB register window. One word holds a shared run mask with one bit per channel. An optional word holds a single output-select bit. Each channel owns a bank of three words: reload constant, live count and control. The banks sit on a 12-byte stride starting at byte 0x08, so channel 0 is at 0x08, channel 1 at 0x14 and channel 2 at 0x20. Accesses that miss every defined word get an error pulse instead of data.

Each channel divides the clock by a selectable power of four. It decrements its count once per divided tick. When a tick finds the count at zero, the channel reloads the constant and latches an underflow flag. Each channel drives its own interrupt line. Build-time parameters choose whether the third channel exists, whether the output-select word exists, and whether prescaler code 7 (external clocking) is legal. The third channel also has a capture interrupt line. Capture itself is not built, so that line is held low.

Top module: `tmrf_unit`

## Requirements
- R1: After reset, every reload constant and every count reads all ones, every control word reads 0, the run mask and output-select bit read 0, and all interrupt lines are low.
- R2: Channel n's bank starts at byte 0x08 + 12*n and holds the constant at +0, the count at +4 and control at +8. Control keeps prescaler code in bits 2:0, interrupt enable in bit 5 and the underflow flag in bit 8; other control bits read 0. The run mask is at 0x04. The output-select bit is at 0x00 bit 0 and drives `out_sel`. Written values read back.
- R3: Run-mask bit n lets channel n count. Bits at or above the channel count are ignored, and the mask reads back as stored.
- R4: While a channel runs with prescaler code c (0 to 4), it ticks once every 4^(c+1) clocks. A tick decrements the count. A tick that finds the count at 0 instead loads the reload constant and sets the underflow flag.
- R5: A stopped channel keeps its count unchanged, and its prescaler phase restarts from zero when it runs again.
- R6: A control write with bit 8 = 0 clears the underflow flag, and a control write with bit 8 = 1 leaves it as it was. An underflow in the same cycle wins over the clear.
- R7: `chan_irq[n]` is high exactly while channel n's underflow flag and interrupt enable are both set.
- R8: Any access to a byte offset outside the defined words is undefined. This covers misaligned offsets, 0x2C and above with three channels, 0x20 and above with two channels, and 0x00 without the output-select option. An undefined access returns 0 on a read, changes nothing on a write, and raises `bus_err` for one cycle.
- R9: A control write with prescaler code 5 or 6, or code 7 when external clocking is not enabled, is ignored as a whole and raises `bus_err`.
- R10: In a two-channel build, a run-mask write with bit 2 set is ignored as a whole and raises `bus_err`, and `chan_irq[2]` stays low.
- R11: Read data and `bus_err` appear in the cycle after the request. `bus_rdata` is 0 in every cycle that does not follow a valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Undefined or illegal access, one cycle after the request |
| out_sel | output | 1 | Output-select bit (0 when the option is absent) |
| chan_irq | output | 3 | Per-channel underflow interrupts |
| cap_irq | output | 1 | Third-channel capture interrupt, held low |

## Verification
The hardest thing to reach from the ports is an underflow and reload landing on a known count. The prescaler phase cannot be read, so the bench controls how long a channel runs. It starts and stops the channel with run-mask writes a fixed number of clocks apart. That window is chosen to sit half a tick away from any tick boundary, so the count after stopping is exactly predictable. The two-channel build has different error rules, so the bench drives a second instance built without the third channel or the output-select word.

// File: rtl/tmrf_pkg.sv
`timescale 1ns/1ps
package tmrf_pkg;

   localparam int PSC_W      = 10;
   localparam int OFS_OCR    = 'h00;
   localparam int OFS_START  = 'h04;
   localparam int BANK_FIRST = 'h08;
   localparam int BANK_BYTES = 12;

   localparam int CF_IE = 5;
   localparam int CF_UF = 8;

   typedef enum logic [1:0] {HIT_NONE, HIT_OCR, HIT_START, HIT_CH} hit_e;
   typedef enum logic [1:0] {RG_CONST, RG_COUNT, RG_CTRL, RG_SPARE} chreg_e;

   typedef struct packed {
      hit_e       hit;
      logic [1:0] ch;
      chreg_e     rg;
   } dec_t;

   function automatic int bank_base(input int idx);
      return BANK_FIRST + BANK_BYTES * idx;
   endfunction

   function automatic logic psc_ok(input logic [2:0] code, input logic ext);
      return (code <= 3'd4) || (ext && code == 3'd7);
   endfunction

   function automatic logic [PSC_W-1:0] psc_last(input logic [2:0] code);
      logic [PSC_W:0] div;
      div = (PSC_W+1)'(4) << {code, 1'b0};
      return PSC_W'(div - 1'b1);
   endfunction

endpackage

// File: rtl/tmrf_decode.sv
`timescale 1ns/1ps
module tmrf_decode
   import tmrf_pkg::*;
#(
   parameter int AW      = 12,
   parameter int NCH     = 3,
   parameter int HAS_OCR = 1
) (
   input  logic [AW-1:0] addr,
   output dec_t          dec
);

   always_comb begin
      dec = '{hit: HIT_NONE, ch: 2'd0, rg: RG_CONST};
      if (addr[1:0] == 2'b00) begin
         if (addr == AW'(OFS_START)) begin
            dec.hit = HIT_START;
         end else if (HAS_OCR != 0 && addr == AW'(OFS_OCR)) begin
            dec.hit = HIT_OCR;
         end
         for (int i = 0; i < NCH; i++) begin
            if (addr >= AW'(bank_base(i)) && addr < AW'(bank_base(i) + BANK_BYTES)) begin
               dec.hit = HIT_CH;
               dec.ch  = 2'(i);
               dec.rg  = chreg_e'(2'((addr - AW'(bank_base(i))) >> 2));
            end
         end
      end
   end

endmodule

// File: rtl/tmrf_chan.sv
`timescale 1ns/1ps
module tmrf_chan
   import tmrf_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             wr_const,
   input  logic             wr_count,
   input  logic             wr_ctrl,
   input  logic [CNT_W-1:0] wdata_cnt,
   input  logic [2:0]       wdata_psc,
   input  logic             wdata_ie,
   input  logic             wdata_uf,
   output logic [31:0]      rd_const,
   output logic [31:0]      rd_count,
   output logic [31:0]      rd_ctrl,
   output logic             irq
);

   logic [CNT_W-1:0] const_q, cnt_q;
   logic [2:0]       code_q;
   logic             ie_q, uf_q;
   logic [PSC_W-1:0] psc_q;
   logic             at_last, tick, wrap;

   assign at_last = (psc_q >= psc_last(code_q));
   assign tick    = run && (code_q != 3'd7) && at_last;
   assign wrap    = tick && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                psc_q <= '0;
      else if (!run || at_last)  psc_q <= '0;
      else                       psc_q <= psc_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         const_q <= '1;
         cnt_q   <= '1;
      end else begin
         if (wr_const) const_q <= wdata_cnt;
         if (wr_count)  cnt_q <= wdata_cnt;
         else if (wrap) cnt_q <= const_q;
         else if (tick) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= 3'd0;
         ie_q   <= 1'b0;
         uf_q   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            code_q <= wdata_psc;
            ie_q   <= wdata_ie;
         end
         if (wrap)                      uf_q <= 1'b1;
         else if (wr_ctrl && !wdata_uf) uf_q <= 1'b0;
      end
   end

   assign rd_const = 32'(const_q);
   assign rd_count = 32'(cnt_q);
   assign rd_ctrl  = 32'(code_q) | (32'(ie_q) << CF_IE) | (32'(uf_q) << CF_UF);
   assign irq      = uf_q & ie_q;

   assert_uf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uf_q) |-> $past(run && cnt_q == '0));

   assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_count) |=> $stable(cnt_q));

endmodule

// File: rtl/tmrf_unit.sv
`timescale 1ns/1ps
module tmrf_unit
   import tmrf_pkg::*;
#(
   parameter int AW       = 12,
   parameter int CNT_W    = 32,
   parameter int THREE_CH = 1,
   parameter int HAS_OCR  = 1,
   parameter int EXT_CLK  = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_req,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic          bus_err,
   output logic          out_sel,
   output logic [2:0]    chan_irq,
   output logic          cap_irq
);

   localparam int NCH = (THREE_CH != 0) ? 3 : 2;

   if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt_w
      $error("tmrf_unit: CNT_W must lie in 8..32");
   end
   if (AW < 6) begin : g_bad_aw
      $error("tmrf_unit: AW too small for the channel banks");
   end

   dec_t dec;
   tmrf_decode #(.AW(AW), .NCH(NCH), .HAS_OCR(HAS_OCR)) u_decode (
      .addr(bus_addr),
      .dec (dec)
   );

   logic bad_ctrl, bad_start, bad, acc_wr, acc_rd;

   always_comb begin
      bad_ctrl  = bus_we && dec.hit == HIT_CH && dec.rg == RG_CTRL
                  && !psc_ok(bus_wdata[2:0], EXT_CLK != 0);
      bad_start = bus_we && dec.hit == HIT_START && (THREE_CH == 0) && bus_wdata[2];
      bad       = bus_req && (dec.hit == HIT_NONE || bad_ctrl || bad_start);
      acc_wr    = bus_req && bus_we && !bad;
      acc_rd    = bus_req && !bus_we && !bad;
   end

   logic [NCH-1:0] start_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                             start_q <= '0;
      else if (acc_wr && dec.hit == HIT_START) start_q <= bus_wdata[NCH-1:0];
   end

   logic ocr_q;
   if (HAS_OCR != 0) begin : g_ocr
      always_ff @(posedge clk) begin
         if (!rst_n)                            ocr_q <= 1'b0;
         else if (acc_wr && dec.hit == HIT_OCR) ocr_q <= bus_wdata[0];
      end
   end else begin : g_no_ocr
      assign ocr_q = 1'b0;
   end
   assign out_sel = ocr_q;

   logic [NCH-1:0][31:0] rd_const, rd_count, rd_ctrl;
   logic [NCH-1:0]       irq_w;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit_me;
      assign hit_me = acc_wr && dec.hit == HIT_CH && dec.ch == 2'(i);
      tmrf_chan #(.CNT_W(CNT_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (start_q[i]),
         .wr_const (hit_me && dec.rg == RG_CONST),
         .wr_count (hit_me && dec.rg == RG_COUNT),
         .wr_ctrl  (hit_me && dec.rg == RG_CTRL),
         .wdata_cnt(bus_wdata[CNT_W-1:0]),
         .wdata_psc(bus_wdata[2:0]),
         .wdata_ie (bus_wdata[CF_IE]),
         .wdata_uf (bus_wdata[CF_UF]),
         .rd_const (rd_const[i]),
         .rd_count (rd_count[i]),
         .rd_ctrl  (rd_ctrl[i]),
         .irq      (irq_w[i])
      );
   end

   if (THREE_CH != 0) begin : g_irq3
      assign chan_irq = irq_w;
   end else begin : g_irq2
      assign chan_irq = {1'b0, irq_w};
   end
   assign cap_irq = 1'b0;

   logic [31:0] rmux;
   always_comb begin
      rmux = '0;
      unique case (dec.hit)
         HIT_OCR:   rmux = {31'd0, ocr_q};
         HIT_START: rmux = 32'(start_q);
         HIT_CH: begin
            for (int i = 0; i < NCH; i++) begin
               if (dec.ch == 2'(i)) begin
                  case (dec.rg)
                     RG_CONST: rmux = rd_const[i];
                     RG_COUNT: rmux = rd_count[i];
                     RG_CTRL:  rmux = rd_ctrl[i];
                     default:  rmux = '0;
                  endcase
               end
            end
         end
         default:   rmux = '0;
      endcase
   end

   logic [31:0] rdata_q;
   logic        err_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         rdata_q <= acc_rd ? rmux : 32'd0;
         err_q   <= bad;
      end
   end
   assign bus_rdata = rdata_q;
   assign bus_err   = err_q;

   assert_err_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_req));

   assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_req) |-> bus_rdata == 32'd0);

   if (THREE_CH == 0) begin : g_start_guard
      assert_start_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_req && bus_we && bus_addr == AW'(OFS_START) && bus_wdata[2])
            |=> ($stable(start_q) && bus_err));
   end

endmodule

// File: tb/test_tmrf_unit.sv
`timescale 1ns/1ps
module test_tmrf_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req [2];
   logic        we  [2];
   logic [11:0] addr [2];
   logic [31:0] wd [2];
   logic [31:0] rd [2];
   logic        er [2];
   logic        osel [2];
   logic [2:0]  irq [2];
   logic        cap [2];

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tmrf_unit i_tmrf_unit (
      .clk(clk), .rst_n(rst_n), .bus_req(req[0]), .bus_we(we[0]), .bus_addr(addr[0]),
      .bus_wdata(wd[0]), .bus_rdata(rd[0]), .bus_err(er[0]), .out_sel(osel[0]),
      .chan_irq(irq[0]), .cap_irq(cap[0]));

   tmrf_unit #(.THREE_CH(0), .HAS_OCR(0)) i_tmrf_unit_two (
      .clk(clk), .rst_n(rst_n), .bus_req(req[1]), .bus_we(we[1]), .bus_addr(addr[1]),
      .bus_wdata(wd[1]), .bus_rdata(rd[1]), .bus_err(er[1]), .out_sel(osel[1]),
      .chan_irq(irq[1]), .cap_irq(cap[1]));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int d, input logic [11:0] a, input logic [31:0] v, output logic e);
      @(negedge clk);
      req[d] = 1'b1; we[d] = 1'b1; addr[d] = a; wd[d] = v;
      @(negedge clk);
      req[d] = 1'b0; we[d] = 1'b0;
      e = er[d];
   endtask

   task automatic rdw(input int d, input logic [11:0] a, output logic [31:0] v, output logic e);
      @(negedge clk);
      req[d] = 1'b1; we[d] = 1'b0; addr[d] = a;
      @(negedge clk);
      req[d] = 1'b0;
      v = rd[d];
      e = er[d];
   endtask

   task automatic t_reset();
      logic [31:0] v; logic e;
      rdw(0, 12'h008, v, e); chk("R1 ch0 const", v, 32'hFFFF_FFFF);
      rdw(0, 12'h00C, v, e); chk("R1 ch0 count", v, 32'hFFFF_FFFF);
      rdw(0, 12'h010, v, e); chk("R1 ch0 ctrl", v, 32'h0);
      rdw(0, 12'h028, v, e); chk("R1 ch2 ctrl", v, 32'h0);
      rdw(0, 12'h004, v, e); chk("R1 run mask", v, 32'h0);
      rdw(0, 12'h000, v, e); chk("R1 out select", v, 32'h0);
      chk("R1 irq lines", {28'd0, cap[0], irq[0]}, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] v; logic e;
      wr(0, 12'h014, 32'hAAAA_5555, e); chk("R2 ch1 const wr err", 32'(e), 0);
      wr(0, 12'h018, 32'h0000_1234, e);
      wr(0, 12'h01C, 32'h0000_0124, e);
      wr(0, 12'h020, 32'h0000_0011, e);
      wr(0, 12'h024, 32'h0000_0022, e);
      wr(0, 12'h028, 32'h0000_FFE3, e); chk("R2 ch2 ctrl wr err", 32'(e), 0);
      rdw(0, 12'h014, v, e); chk("R2 ch1 const", v, 32'hAAAA_5555);
      rdw(0, 12'h018, v, e); chk("R2 ch1 count", v, 32'h0000_1234);
      rdw(0, 12'h01C, v, e); chk("R2 ch1 ctrl", v, 32'h0000_0024);
      rdw(0, 12'h020, v, e); chk("R2 ch2 const", v, 32'h0000_0011);
      rdw(0, 12'h024, v, e); chk("R2 ch2 count", v, 32'h0000_0022);
      rdw(0, 12'h028, v, e); chk("R2 ch2 ctrl fields", v, 32'h0000_0023);
      chk("R2 read err", 32'(e), 0);
   endtask

   task automatic t_count();
      logic [31:0] v; logic e;
      wr(0, 12'h008, 32'd3, e);
      wr(0, 12'h00C, 32'd2, e);
      wr(0, 12'h010, 32'h0000_0120, e);
      wr(0, 12'h004, 32'h1, e);
      repeat (41) @(negedge clk);
      wr(0, 12'h004, 32'h0, e);
      // 43 clocks running at divide-by-4: 10 ticks, 2->0, reload 3, ... -> 0
      rdw(0, 12'h00C, v, e); chk("R4 count after 10 ticks", v, 32'd0);
      rdw(0, 12'h010, v, e); chk("R4 flag set by reload", v, 32'h0000_0120);
      chk("R7 ch0 irq high", 32'(irq[0][0]), 1);
      chk("R7 ch1 irq low", 32'(irq[0][1]), 0);
   endtask

   task automatic t_flag();
      logic [31:0] v; logic e;
      wr(0, 12'h010, 32'h0000_0100, e);
      rdw(0, 12'h010, v, e); chk("R6 flag kept by bit8=1", v, 32'h0000_0100);
      chk("R7 irq low with enable off", 32'(irq[0][0]), 0);
      wr(0, 12'h010, 32'h0000_0000, e);
      rdw(0, 12'h010, v, e); chk("R6 flag cleared by bit8=0", v, 32'h0);
      wr(0, 12'h010, 32'h0000_0020, e);
      chk("R7 irq low with flag clear", 32'(irq[0][0]), 0);
   endtask

   task automatic t_run_mask();
      logic [31:0] v; logic e;
      wr(0, 12'h004, 32'hFFFF_FFFE, e);
      rdw(0, 12'h004, v, e); chk("R3 mask upper bits ignored", v, 32'h6);
      wr(0, 12'h004, 32'h0, e);
      wr(0, 12'h01C, 32'h0000_0001, e);
      wr(0, 12'h018, 32'd5, e);
      wr(0, 12'h004, 32'h6, e);
      repeat (55) @(negedge clk);
      wr(0, 12'h004, 32'h0, e);
      // 57 clocks at divide-by-16: 3 ticks
      rdw(0, 12'h018, v, e); chk("R4 ch1 div16 count", v, 32'd2);
      rdw(0, 12'h00C, v, e); chk("R3 ch0 not run", v, 32'd0);
      repeat (100) @(negedge clk);
      rdw(0, 12'h018, v, e); chk("R5 stopped count held", v, 32'd2);
   endtask

   task automatic t_bad();
      logic [31:0] v; logic e;
      rdw(0, 12'h02C, v, e); chk("R8 0x2C data", v, 0); chk("R8 0x2C err", 32'(e), 1);
      rdw(0, 12'h030, v, e); chk("R8 0x30 err", 32'(e), 1);
      rdw(0, 12'h00A, v, e); chk("R8 misaligned data", v, 0); chk("R8 misaligned err", 32'(e), 1);
      rdw(0, 12'hFFC, v, e); chk("R8 top of window err", 32'(e), 1);
      wr(0, 12'h02C, 32'hFFFF_FFFF, e); chk("R8 write 0x2C err", 32'(e), 1);
      rdw(0, 12'h028, v, e); chk("R8 neighbour unchanged", v, 32'h0000_0023);
      wr(0, 12'h00E, 32'd7, e); chk("R8 misaligned write err", 32'(e), 1);
      rdw(0, 12'h00C, v, e); chk("R8 ch0 count unchanged", v, 32'd0);
   endtask

   task automatic t_timing();
      logic [31:0] v; logic e;
      rdw(0, 12'h014, v, e); chk("R11 read data next cycle", v, 32'hAAAA_5555);
      @(negedge clk);
      chk("R11 rdata returns to 0", rd[0], 0);
      chk("R11 err idle", 32'(er[0]), 0);
      rdw(0, 12'h040, v, e);
      @(negedge clk);
      chk("R11 err lasts one cycle", 32'(er[0]), 0);
   endtask

   task automatic t_psc();
      logic [31:0] v; logic e;
      wr(0, 12'h010, 32'h0000_0025, e); chk("R9 code5 err", 32'(e), 1);
      wr(0, 12'h010, 32'h0000_0006, e); chk("R9 code6 err", 32'(e), 1);
      wr(0, 12'h010, 32'h0000_0007, e); chk("R9 code7 err", 32'(e), 1);
      rdw(0, 12'h010, v, e); chk("R9 ctrl unchanged", v, 32'h0000_0020);
   endtask

   task automatic t_ocr();
      logic [31:0] v; logic e;
      wr(0, 12'h000, 32'hFFFF_FFFF, e);
      rdw(0, 12'h000, v, e); chk("R2 out select reads 1", v, 32'h1);
      chk("R2 out_sel pin", 32'(osel[0]), 1);
      wr(0, 12'h000, 32'h0, e);
      chk("R2 out_sel cleared", 32'(osel[0]), 0);
   endtask

   task automatic t_two();
      logic [31:0] v; logic e;
      rdw(1, 12'h020, v, e); chk("R8 two-ch 0x20 err", 32'(e), 1); chk("R8 two-ch 0x20 data", v, 0);
      rdw(1, 12'h000, v, e); chk("R8 no out select err", 32'(e), 1);
      wr(1, 12'h004, 32'h7, e); chk("R10 bit2 err", 32'(e), 1);
      rdw(1, 12'h004, v, e); chk("R10 mask unchanged", v, 0);
      wr(1, 12'h004, 32'h3, e); chk("R10 legal mask no err", 32'(e), 0);
      rdw(1, 12'h004, v, e); chk("R10 legal mask reads", v, 32'h3);
      wr(1, 12'h004, 32'h0, e);
      chk("R10 chan_irq[2] low", 32'(irq[1][2]), 0);
   endtask

   initial begin
      for (int d = 0; d < 2; d++) begin
         req[d] = 1'b0; we[d] = 1'b0; addr[d] = '0; wd[d] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_count();
      t_flag();
      t_run_mask();
      t_bad();
      t_timing();
      t_psc();
      t_ocr();
      t_two();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule